// File: doc/BRIEF.md
# Hardwired Phase Sequencer for Instruction Fetch

This block is the timing core of a hardwired processor control path. Each instruction is walked through three coarse phases: fetch, address deferral and execution. Every phase is cut into four single-clock steps. The sequencer holds the phase and the step in two separate registers. It forms the datapath strobes for the shared instruction-fetch sequence as plain AND terms of those two registers.

There is one strobe for each source that drives an ALU input bus. There is one for each ALU operation, one for each register loaded from the ALU output bus, and one for the memory read request. The phase code and the one-hot step vector are exposed so that later decode logic can form its own products for the deferral and execution phases. The only inputs are the clock and an asynchronous active-low reset.

Top module: `phase_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, the phase output is 2'b00 (fetch) and the step output is 4'b0001 (first step).
- R2: The step output is always one-hot. On every rising clock edge its single set bit moves one position upward, and bit 3 is followed by bit 0, so each step lasts one clock and recurs every four.
- R3: The phase output changes only on the edge that leaves the last step (step bit 3). On every other edge it holds its value.
- R4: The phase codes follow the order 2'b00 fetch, 2'b01 deferral, 2'b10 execution, then back to 2'b00. The code 2'b11 never appears.
- R5: In fetch with step bit 0 set, `pc_to_b1_o`, `alu_pass_a_o`, `load_mar_o` and `mem_read_o` are high and every other strobe is low.
- R6: In fetch with step bit 1 set, `pc_to_b1_o`, `one_to_b2_o`, `alu_add_o` and `load_pc_o` are high and every other strobe is low.
- R7: In fetch with step bit 2 set, `mbr_to_b2_o`, `alu_pass_b_o` and `load_ir_o` are high and every other strobe is low.
- R8: In fetch with step bit 3 set, and in every step of the deferral and execution phases, all ten strobes are low.
- R9: Whenever any of `load_mar_o`, `load_pc_o` or `load_ir_o` is high, exactly one of `alu_add_o`, `alu_pass_a_o` or `alu_pass_b_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge starts a new step |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_o | output | 2 | Phase code: 00 fetch, 01 deferral, 10 execution |
| step_o | output | 4 | One-hot step vector, bit 0 is the first step |
| pc_to_b1_o | output | 1 | Program counter drives ALU input bus A |
| one_to_b2_o | output | 1 | Constant one drives ALU input bus B |
| mbr_to_b2_o | output | 1 | Memory buffer drives ALU input bus B |
| alu_add_o | output | 1 | ALU adds bus A and bus B |
| alu_pass_a_o | output | 1 | ALU passes bus A to its output bus |
| alu_pass_b_o | output | 1 | ALU passes bus B to its output bus |
| mem_read_o | output | 1 | Memory read request |
| load_mar_o | output | 1 | Memory address register loads the ALU output bus |
| load_pc_o | output | 1 | Program counter loads the ALU output bus |
| load_ir_o | output | 1 | Instruction register loads the ALU output bus |

## Verification
The bench focuses on the boundary where the step wraps from bit 3 to bit 0. A phase register clocked on the wrong step would move one edge early or late, or move on every edge. It also targets the wrap from execution back to fetch, where a plain binary increment would produce the forbidden code 2'b11. Resets are applied at random points in the cycle, including mid-phase, to catch a step ring or phase counter that does not return to its first state. Every strobe is compared against its expected value in every cycle, which exposes any term that is decoded from the wrong step or that leaks into the deferral or execution phases.

// File: rtl/phase_ctl_pkg.sv
package phase_ctl_pkg;

   // Phase codes; the fetch code is decoded by the strobe logic
   typedef enum logic [1:0] {
      PH_FETCH = 2'b00,
      PH_DEFER = 2'b01,
      PH_EXEC  = 2'b10
   } phase_e;

   // Datapath strobe bundle for the shared fetch sequence
   typedef struct packed {
      logic pc_b1;
      logic one_b2;
      logic mbr_b2;
      logic ld_mar;
      logic ld_pc;
      logic ld_ir;
      logic add;
      logic pass_a;
      logic pass_b;
      logic rd;
   } strobe_s;

endpackage

// File: rtl/phase_major_cnt.sv
module phase_major_cnt #(
   parameter int NUM_PHASE = 3,
   parameter int PH_W      = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv_i,
   output logic [PH_W-1:0] phase_o
);
   localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASE - 1);

   logic [PH_W-1:0] cur_q;
   logic [PH_W-1:0] nxt;

   // Any code at or beyond the last legal one wraps to fetch
   always_comb begin
      nxt = cur_q;
      if (adv_i) begin
         if (cur_q >= LAST) nxt = '0;
         else               nxt = cur_q + PH_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= nxt;
   end

   assign phase_o = cur_q;
endmodule

// File: rtl/phase_minor_ring.sv
module phase_minor_ring #(
   parameter int NUM_STEP = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_STEP-1:0] step_o,
   output logic                last_o
);
   localparam logic [NUM_STEP-1:0] FIRST = NUM_STEP'(1);

   logic [NUM_STEP-1:0] ring_q;
   logic [NUM_STEP-1:0] rot;
   logic                legal;

   for (genvar i = 0; i < NUM_STEP; i++) begin : g_rot
      assign rot[i] = ring_q[(i + NUM_STEP - 1) % NUM_STEP];
   end

   assign legal = $onehot(ring_q);

   // A corrupted ring is pulled back to the first step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ring_q <= FIRST;
      else if (legal) ring_q <= rot;
      else            ring_q <= FIRST;
   end

   assign step_o = ring_q;
   assign last_o = legal & ring_q[NUM_STEP-1];
endmodule

// File: rtl/phase_strobe_dec.sv
module phase_strobe_dec
   import phase_ctl_pkg::*;
#(
   parameter int PH_W = 2
) (
   input  logic [PH_W-1:0] phase_i,
   input  logic [2:0]      step_i,
   output strobe_s         stb_o
);
   logic in_fetch;
   logic f_t0, f_t1, f_t2;

   assign in_fetch = (phase_i == PH_W'(PH_FETCH));
   assign f_t0 = in_fetch & step_i[0];
   assign f_t1 = in_fetch & step_i[1];
   assign f_t2 = in_fetch & step_i[2];

   always_comb begin
      stb_o        = '0;
      stb_o.pc_b1  = f_t0 | f_t1;
      stb_o.one_b2 = f_t1;
      stb_o.mbr_b2 = f_t2;
      stb_o.ld_mar = f_t0;
      stb_o.ld_pc  = f_t1;
      stb_o.ld_ir  = f_t2;
      stb_o.add    = f_t1;
      stb_o.pass_a = f_t0;
      stb_o.pass_b = f_t2;
      stb_o.rd     = f_t0;
   end
endmodule

// File: rtl/phase_ctl.sv
module phase_ctl
   import phase_ctl_pkg::*;
#(
   parameter int NUM_PHASE = 3,
   parameter int NUM_STEP  = 4,
   parameter int PH_W      = $clog2(NUM_PHASE)
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [PH_W-1:0]     phase_o,
   output logic [NUM_STEP-1:0] step_o,
   output logic                pc_to_b1_o,
   output logic                one_to_b2_o,
   output logic                mbr_to_b2_o,
   output logic                alu_add_o,
   output logic                alu_pass_a_o,
   output logic                alu_pass_b_o,
   output logic                mem_read_o,
   output logic                load_mar_o,
   output logic                load_pc_o,
   output logic                load_ir_o
);
   if (NUM_STEP < 3) begin : g_bad_step
      $error("phase_ctl: the fetch sequence needs at least three steps");
   end
   if (NUM_PHASE < 2) begin : g_bad_phase
      $error("phase_ctl: at least two phases are required");
   end
   if (PH_W < $clog2(NUM_PHASE)) begin : g_bad_width
      $error("phase_ctl: phase width too small for phase count");
   end

   logic    adv;
   strobe_s stb;

   phase_minor_ring #(.NUM_STEP(NUM_STEP)) ring_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_o (step_o),
      .last_o (adv)
   );

   phase_major_cnt #(.NUM_PHASE(NUM_PHASE), .PH_W(PH_W)) major_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (adv),
      .phase_o (phase_o)
   );

   phase_strobe_dec #(.PH_W(PH_W)) dec_i (
      .phase_i (phase_o),
      .step_i  (step_o[2:0]),
      .stb_o   (stb)
   );

   assign pc_to_b1_o   = stb.pc_b1;
   assign one_to_b2_o  = stb.one_b2;
   assign mbr_to_b2_o  = stb.mbr_b2;
   assign alu_add_o    = stb.add;
   assign alu_pass_a_o = stb.pass_a;
   assign alu_pass_b_o = stb.pass_b;
   assign mem_read_o   = stb.rd;
   assign load_mar_o   = stb.ld_mar;
   assign load_pc_o    = stb.ld_pc;
   assign load_ir_o    = stb.ld_ir;
endmodule

// File: rtl/phase_ctl_chk.sv
module phase_ctl_chk #(
   parameter int NUM_PHASE = 3,
   parameter int NUM_STEP  = 4,
   parameter int PH_W      = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [PH_W-1:0]     phase_o,
   input logic [NUM_STEP-1:0] step_o,
   input logic                pc_to_b1_o,
   input logic                one_to_b2_o,
   input logic                mbr_to_b2_o,
   input logic                alu_add_o,
   input logic                alu_pass_a_o,
   input logic                alu_pass_b_o,
   input logic                mem_read_o,
   input logic                load_mar_o,
   input logic                load_pc_o,
   input logic                load_ir_o
);
   localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASE - 1);

   logic any_strobe;
   assign any_strobe = pc_to_b1_o | one_to_b2_o | mbr_to_b2_o | alu_add_o |
                       alu_pass_a_o | alu_pass_b_o | mem_read_o |
                       load_mar_o | load_pc_o | load_ir_o;

   assert_step_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(step_o));

   assert_step_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> step_o == {$past(step_o[NUM_STEP-2:0]), $past(step_o[NUM_STEP-1])});

   assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !step_o[NUM_STEP-1] |=> $stable(phase_o));

   assert_phase_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o[NUM_STEP-1] && phase_o == LAST) |=> phase_o == '0);

   assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o <= LAST);

   assert_fetch_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == '0 && step_o[0]) |->
         (pc_to_b1_o && alu_pass_a_o && load_mar_o && mem_read_o));

   assert_quiet_outside_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o != '0) |-> !any_strobe);

   assert_single_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_mar_o || load_pc_o || load_ir_o) |->
         $countones({alu_add_o, alu_pass_a_o, alu_pass_b_o}) == 1);
endmodule

bind phase_ctl phase_ctl_chk #(
   .NUM_PHASE (NUM_PHASE),
   .NUM_STEP  (NUM_STEP),
   .PH_W      (PH_W)
) chk_i (.*);

// File: tb/phase_ctl_tb_top.sv
module phase_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] phase_o;
   logic [3:0] step_o;
   logic pc_to_b1_o, one_to_b2_o, mbr_to_b2_o, alu_add_o, alu_pass_a_o;
   logic alu_pass_b_o, mem_read_o, load_mar_o, load_pc_o, load_ir_o;

   int n_checks = 0;
   int n_errors = 0;
   int k = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   phase_ctl dut_i (.*);

   // Strobe word order: pc_b1 one_b2 mbr_b2 ld_mar ld_pc ld_ir add pass_a pass_b rd
   function automatic logic [9:0] port_word();
      return {pc_to_b1_o, one_to_b2_o, mbr_to_b2_o, load_mar_o, load_pc_o,
              load_ir_o, alu_add_o, alu_pass_a_o, alu_pass_b_o, mem_read_o};
   endfunction

   function automatic logic [9:0] exp_word(int ph, int st);
      if (ph != 0) return 10'h000;
      case (st)
         0:       return 10'b1001000101;
         1:       return 10'b1100101000;
         2:       return 10'b0010010010;
         default: return 10'h000;
      endcase
   endfunction

   function automatic string strobe_req(int ph, int st);
      if (ph != 0 || st == 3) return "R8";
      if (st == 0) return "R5";
      if (st == 1) return "R6";
      return "R7";
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, k);
      end
   endtask

   task automatic check_state();
      int ph = (k / 4) % 3;
      int st = k % 4;
      logic [3:0] exp_step = 4'(1 << st);
      chk(step_o == exp_step, "R2", int'(step_o), int'(exp_step));
      if (st == 0) chk(phase_o == 2'(ph), "R4", int'(phase_o), ph);
      else         chk(phase_o == 2'(ph), "R3", int'(phase_o), ph);
      chk(port_word() == exp_word(ph, st), strobe_req(ph, st),
          int'(port_word()), int'(exp_word(ph, st)));
      if (load_mar_o | load_pc_o | load_ir_o)
         chk($countones({alu_add_o, alu_pass_a_o, alu_pass_b_o}) == 1, "R9",
             $countones({alu_add_o, alu_pass_a_o, alu_pass_b_o}), 1);
   endtask

   task automatic do_reset(int hold);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(phase_o == 2'b00 && step_o == 4'b0001, "R1",
          int'({phase_o, step_o}), 6'b000001);
      repeat (hold) @(negedge clk);
      chk(phase_o == 2'b00 && step_o == 4'b0001, "R1",
          int'({phase_o, step_o}), 6'b000001);
      rst_n = 1'b1;
      k = 0;
      check_state();
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         k++;
         @(negedge clk);
         check_state();
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      do_reset(2);
      // Directed: two full passes through all three phases
      run(24);
      // Directed: reset in the middle of execution, then one step
      run(9);
      do_reset(1);
      run(1);
      // Random reset points and run lengths
      for (int seg = 0; seg < 40; seg++) begin
         run(int'($urandom_range(1, 60)));
         do_reset(int'($urandom_range(1, 3)));
      end
      run(13);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule